// File: doc/BRIEF.md
# Message-Buffered SPI Master

This controller runs a complete SPI message from internal byte buffers, with no per-byte handshake. Software fills a transmit window and sets a byte count and a transfer kind. It then writes a command byte that names the target device and launches the message. The engine drives the serial clock, the data-out line and one active-low select per device, and it captures the data-in line into a receive window.

The serial clock comes from the system clock through a power-of-two divider. Software picks one of seven rates, each half the speed of the one before. Clock polarity and phase are both programmable, so all four SPI modes are available. Words are always 8 bits and are sent MSB first. When a message ends, a done flag is set; it drives the interrupt output through a mask bit. A fill counter tells software how many received bytes to read back.

Register map, byte-wide on a simple write-strobe bus with combinational read data. Address bit 5 set selects the data window: writes go to the transmit buffer and reads come from the receive buffer, indexed by the low address bits. Otherwise the address selects a register:
- 0: config
- 1: byte count
- 2: kind
- 3: command
- 4: status
- 5: mask
- 6: receive fill

Top module: `spi_msg_master`

## Requirements
- R1: After reset, every select output is high, sclk sits at the idle level of polarity 0, mosi is low, irq is low, and status (addr 4) and receive fill (addr 6) read 0.
- R2: A write to addr 3 starts a message when all of the following hold: bits[1:0]=01, bits[3:2]=00, and the byte count (addr 1) is between 1 and DEPTH. The start sets status bit1 (busy) and drives low only the select line whose index is bits[5:4]. A command with a nonzero bits[3:2], or with a count of 0 or above DEPTH, is ignored.
- R3: A start command written while busy is ignored, and the active select line does not change.
- R4: Transmit-buffer bytes 0..count-1 go out in order, 8 bits each, MSB first. The select stays low for the whole message and rises one half sclk period after the final clock edge.
- R5: Config bit3 is polarity and sets the sclk idle level. Config bit4 is phase. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R6: Config bits[2:0]=n set the sclk half period to BASE_HALF<<n system clocks. The code 7 acts as 6.
- R7: Kind register (addr 2) bits[1:0]:
  - 0 and 3: full duplex.
  - 1: read-only. mosi stays low and received bytes are stored.
  - 2: write-only. miso is ignored, the receive buffer is left untouched and the fill stays 0.
- R8: Receive fill (addr 6) reports the number of bytes stored in the current message. Byte k reads back at addr 32+k.
- R9: Status bit0 (done) sets in the same cycle that busy clears. Writing 0xFF to addr 4 clears it, and any other value leaves it set.
- R10: irq is high exactly when done is set and mask bit0 (addr 5) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register/buffer write strobe |
| bus_addr | input | ADDR_W | Register or buffer address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low device selects |
| irq | output | 1 | Masked message-done interrupt |

## Verification
A bench-side SPI device follows the programmed mode. It shifts a per-message byte pattern onto miso and assembles what arrives on mosi, and a scoreboard compares each assembled byte against the bytes queued when the message was set up.

Messages are run as follows:
- All four modes, so that a mode mix-up shows as bit-shifted bytes.
- All three transfer kinds, which separates a zeroed mosi and an untouched receive buffer from normal full duplex.
- Lengths of 1, 2, 3 and the full buffer, which exposes off-by-one errors at byte boundaries.
- Rates at both ends, measured as a half-period count, which catches a wrong divider shift.

A start issued while busy, a command with a nonzero prepend field, and counts of 0 and DEPTH+1 each check that nothing was started. A non-clear status write checks that done is held.

// File: rtl/spi_msg_master.sv
module spi_msg_master #(
  parameter int DEPTH     = 16,
  parameter int NUM_CS    = 4,
  parameter int BASE_HALF = 1,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              irq
);
  localparam int IW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int IDW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int TW  = $clog2(BASE_HALF * 64 + 1);

  logic [2:0]    rate;
  logic          cpol, cpha, mask, done, busy, ending, sck_ph, mo;
  logic [CW-1:0] count, rx_tail;
  logic [1:0]    mtype;
  logic [IDW-1:0] cs_sel;
  logic [TW-1:0] tcnt;
  logic [3:0]    ecnt;
  logic [IW-1:0] bidx;
  logic [7:0]    txsh, rxsh;
  logic [7:0]    txbuf [DEPTH];
  logic [7:0]    rxbuf [DEPTH];

  wire is_buf = bus_addr[ADDR_W-1];
  wire [IW-1:0] widx = bus_addr[IW-1:0];
  wire cmd_wr = bus_we && bus_addr == ADDR_W'(3);
  wire start = cmd_wr && bus_wdata[1:0] == 2'b01 && bus_wdata[3:2] == 2'b00 && !busy
               && count != '0 && count <= CW'(DEPTH);

  wire [2:0]    rsel = (rate == 3'd7) ? 3'd6 : rate;
  wire [TW-1:0] half = TW'(BASE_HALF) << rsel;
  wire          tick = tcnt == half - TW'(1);
  wire          lead = ~ecnt[0];
  wire          samp = lead ^ cpha;
  wire          last_bit  = ecnt == 4'd15;
  wire          last_byte = CW'(bidx) == count - CW'(1);
  wire [IW-1:0] ld_idx  = start ? '0 : bidx + IW'(1);
  wire [7:0]    ld_byte = (mtype == 2'd1) ? 8'h00 : txbuf[ld_idx];
  wire [7:0]    rx_in   = cpha ? {rxsh[6:0], miso} : rxsh;
  wire          store   = busy && tick && !ending && last_bit && mtype != 2'd2;

  assign cs_n = busy ? ~(NUM_CS'(1) << cs_sel) : '1;
  assign sclk = (busy & sck_ph) ^ cpol;
  assign mosi = busy & mo;
  assign irq  = done & mask;

  always_ff @(posedge clk) begin
    if (bus_we && is_buf) txbuf[widx] <= bus_wdata;
    if (store) rxbuf[bidx] <= rx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate <= '0; cpol <= 1'b0; cpha <= 1'b0; mask <= 1'b0; done <= 1'b0;
      busy <= 1'b0; ending <= 1'b0; sck_ph <= 1'b0; mo <= 1'b0;
      count <= '0; rx_tail <= '0; mtype <= '0; cs_sel <= '0;
      tcnt <= '0; ecnt <= '0; bidx <= '0; txsh <= '0; rxsh <= '0;
    end else begin
      if (bus_we && !is_buf) begin
        case (bus_addr)
          ADDR_W'(0): {cpha, cpol, rate} <= bus_wdata[4:0];
          ADDR_W'(1): count <= bus_wdata[CW-1:0];
          ADDR_W'(2): mtype <= bus_wdata[1:0];
          ADDR_W'(4): if (bus_wdata == 8'hFF) done <= 1'b0;
          ADDR_W'(5): mask <= bus_wdata[0];
          default: ;
        endcase
      end
      if (start) begin
        busy <= 1'b1; ending <= 1'b0; sck_ph <= 1'b0;
        cs_sel <= bus_wdata[4 +: IDW];
        tcnt <= '0; ecnt <= '0; bidx <= '0; rx_tail <= '0;
        if (cpha) begin txsh <= ld_byte; mo <= 1'b0; end
        else begin txsh <= {ld_byte[6:0], 1'b0}; mo <= ld_byte[7]; end
      end else if (busy) begin
        if (!tick) tcnt <= tcnt + TW'(1);
        else begin
          tcnt <= '0;
          if (ending) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            sck_ph <= ~sck_ph;
            ecnt   <= ecnt + 4'd1;
            if (samp) rxsh <= {rxsh[6:0], miso};
            else if (!(last_bit && !cpha)) begin
              mo   <= txsh[7];
              txsh <= {txsh[6:0], 1'b0};
            end
            if (last_bit) begin
              if (mtype != 2'd2) rx_tail <= rx_tail + CW'(1);
              if (last_byte) ending <= 1'b1;
              else begin
                bidx <= bidx + IW'(1);
                if (cpha) txsh <= ld_byte;
                else begin txsh <= {ld_byte[6:0], 1'b0}; mo <= ld_byte[7]; end
              end
            end
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (is_buf) bus_rdata = rxbuf[widx];
    else begin
      case (bus_addr)
        ADDR_W'(0): bus_rdata = {3'b000, cpha, cpol, rate};
        ADDR_W'(1): bus_rdata = 8'(count);
        ADDR_W'(2): bus_rdata = {6'b0, mtype};
        ADDR_W'(4): bus_rdata = {6'b0, busy, done};
        ADDR_W'(5): bus_rdata = {7'b0, mask};
        ADDR_W'(6): bus_rdata = 8'(rx_tail);
        default:    bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

module spi_msg_master_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              cpol,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n,
  input logic              cmd_wr
);
  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(~cs_n) == 1);
  // R4
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> &cs_n);
  // R4
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));
  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> (!busy || $stable(cs_n)));
  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);
  // R9
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind spi_msg_master spi_msg_master_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cpol(cpol),
  .sclk(sclk), .cs_n(cs_n), .cmd_wr(cmd_wr));

// File: tb/spi_msg_master_bench.sv
module spi_msg_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int NUM_CS = 4;
  localparam int BASE_HALF = 1;

  logic clk = 0, rst_n = 0, bus_we = 0, miso = 0;
  logic [5:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic sclk, mosi, irq;
  logic [NUM_CS-1:0] cs_n;

  int checks = 0, errors = 0;
  bit finished = 0;
  byte unsigned exp_q[$];
  logic [7:0] seed = 8'h00;
  logic s_cpol = 0, s_cpha = 0;
  logic prev_sclk = 0, prev_act = 0;
  logic [7:0] cap, sh;
  int nb = 0, dd = 0, kk = 0;
  logic [7:0] last_rx0 = 8'h00;
  logic cur_mask = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_msg_master #(.DEPTH(DEPTH), .NUM_CS(NUM_CS), .BASE_HALF(BASE_HALF), .ADDR_W(6)) u_spi_msg_master (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq));

  function automatic logic [7:0] miso_byte(int k);
    return 8'h3C ^ 8'(k * 29) ^ seed;
  endfunction
  function automatic logic [7:0] tx_byte(int k);
    return 8'h81 ^ 8'(k * 7) ^ {seed[3:0], seed[7:4]};
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic drive_bit();
    if (dd == 8) begin kk++; sh = miso_byte(kk); dd = 0; end
    miso = sh[7]; sh = {sh[6:0], 1'b0}; dd++;
  endtask

  // device model and scoreboard monitor, evaluated away from the active edge
  always @(negedge clk) begin
    logic act;
    act = cs_n != '1;
    if (act && !prev_act) begin
      kk = 0; dd = 0; nb = 0; sh = miso_byte(0);
      if (!s_cpha) drive_bit();
    end else if (act && sclk != prev_sclk) begin
      if ((sclk != s_cpol) ^ s_cpha) begin
        cap = {cap[6:0], mosi}; nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) check(0, "R4 unexpected byte", cap, 0);
          else begin
            byte unsigned e;
            e = exp_q.pop_front();
            check(cap == e, "R4/R5/R7 mosi byte", cap, e);
          end
        end
      end else drive_bit();
    end
    prev_act = act; prev_sclk = sclk;
  end

  task automatic bus_write(int a, logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic bus_read(int a, output logic [7:0] d);
    @(negedge clk); bus_addr = 6'(a); #1; d = bus_rdata;
  endtask

  task automatic run_msg(int typ, int len, int id, int rate, bit pol, bit pha, bit meas);
    logic [7:0] d;
    int hexp, n;
    seed = seed + 8'h53;
    s_cpol = pol; s_cpha = pha;
    bus_write(0, {3'b0, pha, pol, 3'(rate)});
    for (int k = 0; k < len; k++) begin
      bus_write(32 + k, tx_byte(k));
      exp_q.push_back(typ == 1 ? 8'h00 : tx_byte(k));
    end
    bus_write(1, 8'(len));
    bus_write(2, 8'(typ));
    bus_write(3, {2'b00, 2'(id), 2'b00, 2'b01});
    bus_read(4, d);
    check(d[1] == 1'b1, "R2 busy after start", d, 2);
    check(cs_n == ~(4'b1 << id), "R2 select line", cs_n, ~(4'b1 << id));
    bus_write(3, {2'b00, 2'(id + 1), 2'b00, 2'b01});
    check(cs_n == ~(4'b1 << id), "R3 restart ignored", cs_n, ~(4'b1 << id));
    if (meas) begin
      hexp = BASE_HALF << (rate == 7 ? 6 : rate);
      while (sclk != pol) @(negedge clk);
      while (sclk == pol) @(negedge clk);
      n = 0;
      while (sclk != pol) begin @(negedge clk); n++; end
      check(n == hexp, "R6 half period", n, hexp);
    end
    d = 0;
    for (int i = 0; i < 6000 && !d[0]; i++) bus_read(4, d);
    check(d == 8'h01, "R9 done with busy clear", d, 1);
    check(irq == cur_mask, "R10 irq follows mask", irq, cur_mask);
    check(cs_n == '1 && sclk == pol, "R4/R5 idle after message", {sclk, cs_n}, {pol, 4'hF});
    check(exp_q.size() == 0, "R4 all bytes shifted", exp_q.size(), 0);
    bus_read(6, d);
    check(d == (typ == 2 ? 0 : len), "R8 receive fill", d, typ == 2 ? 0 : len);
    if (typ != 2) begin
      for (int k = 0; k < len; k++) begin
        bus_read(32 + k, d);
        check(d == miso_byte(k), "R7/R8 rx byte", d, miso_byte(k));
      end
      last_rx0 = miso_byte(0);
    end else begin
      bus_read(32, d);
      check(d == last_rx0, "R7 write-only leaves rx buffer", d, last_rx0);
    end
    bus_write(4, 8'h01);
    bus_read(4, d);
    check(d[0] == 1'b1, "R9 non-clear write keeps done", d, 1);
    bus_write(4, 8'hFF);
    bus_read(4, d);
    check(d == 8'h00 && irq == 1'b0, "R9/R10 clear-all", {irq, d}, 0);
  endtask

  task automatic try_bad(int len, logic [7:0] cmd, string tag);
    logic [7:0] d;
    bus_write(1, 8'(len));
    bus_write(3, cmd);
    bus_read(4, d);
    check(d == 8'h00 && cs_n == '1, tag, {d, cs_n}, 4'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1
    check(cs_n == '1 && sclk == 0 && mosi == 0 && irq == 0, "R1 reset outputs",
          {cs_n, sclk, mosi, irq}, 8'h78);
    rst_n = 1;
    bus_read(4, d); check(d == 0, "R1 status reset", d, 0);
    bus_read(6, d); check(d == 0, "R1 fill reset", d, 0);
    cur_mask = 1; bus_write(5, 8'h01);
    run_msg(0, 3, 0, 0, 0, 0, 0);
    run_msg(1, 2, 1, 1, 0, 1, 1);
    cur_mask = 0; bus_write(5, 8'h00);
    run_msg(2, 2, 2, 2, 1, 0, 1);
    cur_mask = 1; bus_write(5, 8'h01);
    run_msg(0, 2, 3, 7, 1, 1, 1);
    run_msg(0, DEPTH, 1, 0, 0, 0, 0);
    run_msg(3, 1, 2, 0, 1, 0, 0);
    // R2 ignored commands
    try_bad(2, 8'h05, "R2 nonzero prepend ignored");
    try_bad(0, 8'h01, "R2 zero count ignored");
    try_bad(DEPTH + 1, 8'h01, "R2 oversize count ignored");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule